// File: doc/BRIEF.md
# Key-Sequence Watchdog Reset Controller

This block guards a system with a 64-bit watchdog counter that must be armed through a fixed two-key handshake. Software writes a 32-bit control word that carries a 16-bit key and an enable flag. The first arming key moves the block from idle to a half-armed state. The second arming key starts the watchdog. Arming is accepted only while the timer-mode input selects watchdog mode. Once running, the counter advances on each tick pulse. Software must periodically write the same two keys in order to clear the counter.

A key written out of order while the watchdog runs raises a reset request at once. A counter that reaches the programmed period also raises it. The request stays high until the block's own reset. After that, the counter freezes and further writes have no effect. Clock gating and reset distribution belong to the surrounding chip.

Top module: `wdk_guard`

## Requirements
- R1: After reset, `count_o` is 0 and `rst_req` is 0.
- R2: While idle, a write arms the first stage only if all three conditions hold: the key in bits 31:16 is 0xA5C6, bit 14 is 1, and `tmr_mode` is 2. Any other write is ignored, and the counter stays at 0.
- R3: In the half-armed state, a write of key 0xDA7E with bit 14 set starts the watchdog. Any other write is ignored, with no reset request, and the counter stays at 0.
- R4: While running, writing key 0xA5C6 and then key 0xDA7E clears the counter to 0 one cycle after the second write. Counting then resumes.
- R5: While running, each cycle with `tick` high increments `count_o` by one.
- R6: While running with no service in progress, a write of any key other than 0xA5C6 sets `rst_req` on the next cycle.
- R7: After the first service key, a write of any key other than 0xDA7E sets `rst_req` on the next cycle.
- R8: While running, a tick that finds `count_o` equal to `period` sets `rst_req` on the next cycle. With period P, this is the (P+1)-th tick after arming or service.
- R9: A period of 0 raises `rst_req` on the first tick after arming.
- R10: Once running, bit 14 of a write is ignored. A write with bit 14 clear neither disarms the watchdog nor changes how keys are judged.
- R11: `rst_req`, once high, stays high and `count_o` stays frozen until `rst` is asserted, whatever is written or ticked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 32 | Control word: key in 31:16, enable in 14 |
| tmr_mode | input | 2 | Timer mode; 2 selects watchdog mode |
| period | input | 64 | Expiry compare value |
| tick | input | 1 | Count enable pulse |
| count_o | output | 64 | Current counter value |
| rst_req | output | 1 | Sticky reset request |

## Verification
The bench first targets the arming gate. It writes the first key with the enable flag clear and then with the wrong timer mode, and checks that the block stays idle. A design that accepted either write would start counting after a later second key. It also sends junk writes to the half-armed state, where a design that faulted or disarmed would raise a spurious request or refuse the later valid key. In the running state, it drives out-of-order keys in both positions of the service pair and expects an immediate request. It then checks expiry at period 3 and at period 0, where an off-by-one compare would trip one tick early or late. Finally, it writes keys with the enable flag clear, which a design that let software disarm would mishandle, and it checks that the request stays sticky.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
    localparam int          CTRL_W    = 32;
    localparam int          KEY_W     = 16;
    localparam int          KEY_LSB   = 16;
    localparam int          EN_BIT    = 14;
    localparam logic [KEY_W-1:0] KEY_FIRST  = 16'hA5C6;
    localparam logic [KEY_W-1:0] KEY_SECOND = 16'hDA7E;
    localparam logic [1:0]  MODE_WDOG = 2'd2;

    typedef enum logic [1:0] {
        WD_OFF = 2'd0,
        WD_PRE = 2'd1,
        WD_RUN = 2'd2,
        WD_SVC = 2'd3
    } wd_phase_e;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic             en;
    } ctl_word_t;

    function automatic ctl_word_t split_ctl(input logic [CTRL_W-1:0] d);
        ctl_word_t c;
        c.key = d[KEY_LSB +: KEY_W];
        c.en  = d[EN_BIT];
        return c;
    endfunction
endpackage

// File: rtl/wdk_key_fsm.sv
module wdk_key_fsm
    import wdk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              halt,
    input  logic              wr_en,
    input  ctl_word_t         ctl,
    input  logic [1:0]        tmr_mode,
    output wd_phase_e         phase,
    output logic              arm_clr,
    output logic              svc_clr,
    output logic              key_fault
);
    wd_phase_e phase_nxt;

    always_comb begin
        phase_nxt = phase;
        arm_clr   = 1'b0;
        svc_clr   = 1'b0;
        key_fault = 1'b0;
        if (wr_en && !halt) begin
            unique case (phase)
                WD_OFF: begin
                    if (ctl.en && ctl.key == KEY_FIRST && tmr_mode == MODE_WDOG) begin
                        phase_nxt = WD_PRE;
                        arm_clr   = 1'b1;
                    end
                end
                WD_PRE: begin
                    if (ctl.en && ctl.key == KEY_SECOND)
                        phase_nxt = WD_RUN;
                end
                WD_RUN: begin
                    if (ctl.key == KEY_FIRST) phase_nxt = WD_SVC;
                    else                      key_fault = 1'b1;
                end
                WD_SVC: begin
                    if (ctl.key == KEY_SECOND) begin
                        phase_nxt = WD_RUN;
                        svc_clr   = 1'b1;
                    end else begin
                        key_fault = 1'b1;
                    end
                end
                default: phase_nxt = WD_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= WD_OFF;
        else     phase <= phase_nxt;
    end
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             clr,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign expire = run && tick && (count == period);

    always_ff @(posedge clk) begin
        if (rst)                        count <= '0;
        else if (clr)                   count <= '0;
        else if (run && tick && !expire) count <= count + ONE;
    end
endmodule

// File: rtl/wdk_guard.sv
module wdk_guard
    import wdk_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic [1:0]        tmr_mode,
    input  logic [CNT_W-1:0]  period,
    input  logic              tick,
    output logic [CNT_W-1:0]  count_o,
    output logic              rst_req
);
    ctl_word_t ctl;
    wd_phase_e phase;
    logic      arm_clr, svc_clr, key_fault, expire, running;
    logic      unused_bits;

    assign ctl         = split_ctl(wr_data);
    assign unused_bits = ^{wr_data[15], wr_data[13:0]};
    assign running     = (phase == WD_RUN || phase == WD_SVC) && !rst_req;

    wdk_key_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .halt      (rst_req),
        .wr_en     (wr_en),
        .ctl       (ctl),
        .tmr_mode  (tmr_mode),
        .phase     (phase),
        .arm_clr   (arm_clr),
        .svc_clr   (svc_clr),
        .key_fault (key_fault)
    );

    wdk_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (running),
        .tick   (tick),
        .clr    (arm_clr | svc_clr),
        .period (period),
        .count  (count_o),
        .expire (expire)
    );

    always_ff @(posedge clk) begin
        if (rst)                    rst_req <= 1'b0;
        else if (key_fault || expire) rst_req <= 1'b1;
    end
endmodule

// File: rtl/wdk_checker.sv
module wdk_checker
    import wdk_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [CTRL_W-1:0] wr_data,
    input logic              tick,
    input logic [CNT_W-1:0]  period,
    input logic [CNT_W-1:0]  count_o,
    input logic              rst_req,
    input logic [1:0]        phase
);
    assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> rst_req && $stable(count_o));

    assert_badkey_run_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == WD_RUN && wr_en && wr_data[31:16] != KEY_FIRST) |=> rst_req);

    assert_badkey_svc_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == WD_SVC && wr_en && wr_data[31:16] != KEY_SECOND) |=> rst_req);

    assert_expire_R8: assert property (@(posedge clk) disable iff (rst)
        ((phase == WD_RUN || phase == WD_SVC) && tick && count_o == period) |=> rst_req);

    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == WD_OFF || phase == WD_PRE) |-> (count_o == '0 && !rst_req));

    assert_pre_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == WD_PRE && wr_en && wr_data[31:16] != KEY_SECOND) |=> phase == WD_PRE);

    assert_no_disarm_R10: assert property (@(posedge clk) disable iff (rst)
        (phase == WD_RUN || phase == WD_SVC) |=> (phase == WD_RUN || phase == WD_SVC));

    assert_service_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == WD_SVC && wr_en && wr_data[31:16] == KEY_SECOND && !rst_req) |=> count_o == '0);
endmodule

bind wdk_guard wdk_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .tick    (tick),
    .period  (period),
    .count_o (count_o),
    .rst_req (rst_req),
    .phase   (phase)
);

// File: tb/tb_wdk_guard.sv
module tb_wdk_guard;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  tmr_mode = 2'd2;
    logic [63:0] period = 64'd100;
    logic        tick = 1'b0;
    logic [63:0] count_o;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdk_guard dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .tmr_mode(tmr_mode), .period(period), .tick(tick),
        .count_o(count_o), .rst_req(rst_req)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; wr_en = 1'b0; tick = 1'b0; tmr_mode = 2'd2;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic wr(input logic [15:0] key, input logic en);
        @(negedge clk); wr_en = 1'b1; wr_data = {key, 1'b0, en, 14'h0};
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic arm();
        wr(16'hA5C6, 1'b1);
        wr(16'hDA7E, 1'b1);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 count", count_o, 64'd0);
        check("R1 rst_req", {63'd0, rst_req}, 64'd0);
    endtask

    task automatic t_count();
        do_reset(); period = 64'd100; arm(); ticks(5);
        check("R5 count", count_o, 64'd5);
        check("R5 rst_req", {63'd0, rst_req}, 64'd0);
    endtask

    task automatic t_idle_ignore();
        do_reset(); period = 64'd100;
        tmr_mode = 2'd1; wr(16'hA5C6, 1'b1); tmr_mode = 2'd2;
        wr(16'hA5C6, 1'b0);
        wr(16'h1234, 1'b1);
        wr(16'hDA7E, 1'b1); ticks(4);
        check("R2 count", count_o, 64'd0);
        check("R2 rst_req", {63'd0, rst_req}, 64'd0);
    endtask

    task automatic t_pre_ignore();
        do_reset(); period = 64'd100;
        wr(16'hA5C6, 1'b1); wr(16'h1111, 1'b1); wr(16'hDA7E, 1'b0); ticks(3);
        check("R3 count held", count_o, 64'd0);
        check("R3 no reset", {63'd0, rst_req}, 64'd0);
        wr(16'hDA7E, 1'b1); ticks(3);
        check("R3 armed", count_o, 64'd3);
    endtask

    task automatic t_service();
        do_reset(); period = 64'd100; arm(); ticks(7);
        wr(16'hA5C6, 1'b1);
        check("R4 mid", count_o, 64'd7);
        wr(16'hDA7E, 1'b1);
        check("R4 cleared", count_o, 64'd0);
        check("R4 rst_req", {63'd0, rst_req}, 64'd0);
        ticks(2);
        check("R4 resumed", count_o, 64'd2);
    endtask

    task automatic t_badkey();
        do_reset(); arm(); wr(16'hBEEF, 1'b1);
        check("R6 junk key", {63'd0, rst_req}, 64'd1);
        do_reset(); arm(); wr(16'hDA7E, 1'b1);
        check("R6 second key first", {63'd0, rst_req}, 64'd1);
    endtask

    task automatic t_bad_second();
        do_reset(); arm(); wr(16'hA5C6, 1'b1); wr(16'hA5C6, 1'b1);
        check("R7 repeat first key", {63'd0, rst_req}, 64'd1);
    endtask

    task automatic t_expire();
        do_reset(); period = 64'd3; arm(); ticks(3);
        check("R8 count", count_o, 64'd3);
        check("R8 not yet", {63'd0, rst_req}, 64'd0);
        ticks(1);
        check("R8 tripped", {63'd0, rst_req}, 64'd1);
    endtask

    task automatic t_zero();
        do_reset(); period = 64'd0; arm();
        check("R9 before tick", {63'd0, rst_req}, 64'd0);
        ticks(1);
        check("R9 first tick", {63'd0, rst_req}, 64'd1);
    endtask

    task automatic t_enable_clear();
        do_reset(); period = 64'd100; arm(); ticks(4);
        wr(16'hA5C6, 1'b0); wr(16'hDA7E, 1'b0);
        check("R10 serviced", count_o, 64'd0);
        check("R10 no reset", {63'd0, rst_req}, 64'd0);
        ticks(2);
        check("R10 still running", count_o, 64'd2);
        wr(16'h0000, 1'b0);
        check("R10 still judged", {63'd0, rst_req}, 64'd1);
    endtask

    task automatic t_sticky();
        do_reset(); period = 64'd2; arm(); ticks(3);
        check("R11 tripped", {63'd0, rst_req}, 64'd1);
        check("R11 frozen value", count_o, 64'd2);
        wr(16'hA5C6, 1'b1); wr(16'hDA7E, 1'b1); ticks(5);
        check("R11 held", {63'd0, rst_req}, 64'd1);
        check("R11 still frozen", count_o, 64'd2);
        do_reset();
        check("R11 cleared by rst", {63'd0, rst_req}, 64'd0);
    endtask

    initial begin
        fork
            begin
                t_reset(); t_count(); t_idle_ignore(); t_pre_ignore();
                t_service(); t_badkey(); t_bad_second(); t_expire();
                t_zero(); t_enable_clear(); t_sticky();
                done = 1'b1;
            end
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    checks++; errors++;
                    $display("FAIL watchdog: actual hung expected done");
                end
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule